// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiplier

This block multiplies two signed two's complement words of `WIDTH` bits and returns their full `2*WIDTH`-bit product. It uses one row of carry-save full adders many times over instead of a full array, so its area grows linearly with `WIDTH`. Each iteration takes a radix-4 Booth digit from the A operand. A selector builds 0, ±B or ±2B from B by shifting and inverting. Where the multiple is negative, the missing +1 is added one step later at the low end of the running sum. The carry-save accumulator moves two places toward the LSB on every iteration.

The three bits that leave the bottom of the accumulator are the two low sum bits and the lowest carry bit. A small resolve stage adds them, together with its own carry fed back from the previous step, and produces two finished product bits per step. Those bits enter the top of the A register as its Booth pairs are used up, so that register ends up holding the low half of the product. After the last Booth digit, one drain step resolves the final bits and folds a constant sign correction into the carry-save words. A ripple adder then forms the high half.

The surrounding controller loads the operands with `load_i`. It then gives one `step_i` pulse per iteration, at whatever pace it likes, and reads `product_o` once `ready_o` is high.

Top module: `iter_booth_mul`

## Requirements
- R1: After reset, `ready_o` is 1 and `product_o` is 0.
- R2: A cycle with `load_i` high captures `a_i` and `b_i`, and `ready_o` is 0 in the following cycle.
- R3: After a load, `ready_o` stays 0 until exactly `WIDTH/2 + 2` step pulses have been accepted. It goes to 1 in the cycle after the last of them.
- R4: When `ready_o` is 1 after a multiply, `product_o` holds the signed product of the loaded operands as a `2*WIDTH`-bit two's complement value. The low `WIDTH` bits are in `product_o[WIDTH-1:0]`.
- R5: Corner operands give exact results: most-negative times most-negative gives `2^(2*WIDTH-2)`, any operand times zero gives 0, and multiplying by -1 gives the negation at full width.
- R6: Cycles with `step_i` low pause the iteration. Idle gaps of any length between steps do not change the result or the step count needed.
- R7: Once `ready_o` is 1, further `step_i` pulses have no effect. `product_o` and `ready_o` hold until the next load.
- R8: When `load_i` and `step_i` are high in the same cycle, the load wins and the step is not counted toward the `WIDTH/2 + 2` steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture operands and start a new multiply |
| a_i | input | WIDTH | Operand A, signed; the Booth-recoded operand |
| b_i | input | WIDTH | Operand B, signed; the multiplicand |
| step_i | input | 1 | Advance one iteration |
| product_o | output | 2*WIDTH | Signed product, valid while `ready_o` is 1 |
| ready_o | output | 1 | Product complete |

## Verification
The assertions check the control behaviour on every cycle. A load must drop `ready_o` on the next cycle. `ready_o` may only rise after an accepted step. The step counter must stay in range. The product and ready flag must hold through idle cycles and through steps taken after completion. Arithmetic correctness cannot be checked cycle by cycle, because the carry-save state is redundant and only the finished product has a meaning. So the bench scenarios cover it: random operand pairs, the extreme and sign-mixing corner values, stepping with idle gaps, extra steps after completion, and a step pulse that coincides with a load.

// File: rtl/iter_booth_mul_pkg.sv
package iter_booth_mul_pkg;

  typedef struct packed {
    logic zero;
    logic two;
    logic neg;
  } booth_dig_t;

  // trip = {a[1], a[0], previous shifted-out bit}
  function automatic booth_dig_t booth_code(input logic [2:0] trip);
    booth_dig_t d;
    d = '{zero: 1'b0, two: 1'b0, neg: 1'b0};
    unique case (trip)
      3'b000, 3'b111: d.zero = 1'b1;
      3'b001, 3'b010: d = '{zero: 1'b0, two: 1'b0, neg: 1'b0};
      3'b011:         d.two = 1'b1;
      3'b100:         d = '{zero: 1'b0, two: 1'b1, neg: 1'b1};
      default:        d.neg = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth_dec.sv
module booth_dec
  import iter_booth_mul_pkg::*;
(
  input  logic [1:0] pair_i,
  input  logic       prev_i,
  output booth_dig_t dig_o
);
  always_comb dig_o = booth_code({pair_i, prev_i});
endmodule

// File: rtl/mul_sel.sv
module mul_sel
  import iter_booth_mul_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int W = WIDTH + 2
) (
  input  logic [WIDTH-1:0] b_i,
  input  booth_dig_t       dig_i,
  output logic [W-1:0]     mult_o
);
  logic [W-1:0] b_ext, mag, sel;

  always_comb begin
    b_ext = {{2{b_i[WIDTH-1]}}, b_i};
    if (dig_i.zero)     mag = '0;
    else if (dig_i.two) mag = {b_ext[W-2:0], 1'b0};
    else                mag = b_ext;
    // ones' complement only; the +1 is injected in the resolve stage
    sel = dig_i.neg ? ~mag : mag;
    // bias by 2^(W-1) so every multiple is a non-negative unsigned word
    mult_o = {~sel[W-1], sel[W-2:0]};
  end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 18
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
    assign cry_o[i] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
  end
endmodule

// File: rtl/resolve_unit.sv
module resolve_unit (
  input  logic [1:0] sum_i,
  input  logic       cry_i,
  input  logic       neg_i,
  input  logic       cin_i,
  output logic [1:0] bits_o,
  output logic       cout_o
);
  logic [2:0] tot;
  always_comb begin
    tot    = {1'b0, sum_i} + {1'b0, cry_i, 1'b0} + {2'b00, neg_i} + {2'b00, cin_i};
    bits_o = tot[1:0];
    cout_o = tot[2];
  end
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH:0] cy;
  assign cy[0] = cin_i;
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
    assign cy[i+1]  = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
  end
endmodule

// File: rtl/iter_booth_mul.sv
module iter_booth_mul
  import iter_booth_mul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               step_i,
  output logic [2*WIDTH-1:0] product_o,
  output logic               ready_o
);
  localparam int W     = WIDTH + 2;
  localparam int K     = WIDTH / 2;
  localparam int CW    = $clog2(K + 3);
  localparam logic [CW-1:0] DRAIN = CW'(K);
  localparam logic [CW-1:0] SUMUP = CW'(K + 1);
  localparam logic [CW-1:0] DONE  = CW'(K + 2);

  // negated high half of the accumulated per-digit bias (bits 1,3,5,..)
  function automatic logic [WIDTH-1:0] hi_corr();
    logic [WIDTH-1:0] b;
    b = '0;
    for (int j = 0; j < K; j++) b[2*j+1] = 1'b1;
    return ~b + 1'b1;
  endfunction
  localparam logic [WIDTH-1:0] CORR = hi_corr();

  logic [WIDTH-1:0] a_q, b_q, hi_q;
  logic             prev_q, rc_q;
  logic [W-1:0]     s_q, c_q;
  logic [1:0]       pend_s_q;
  logic             pend_c_q, pend_n_q;
  logic [CW-1:0]    cnt_q;

  booth_dig_t   dig;
  logic [W-1:0] mult, addend, csa_s, csa_c;
  logic [1:0]   res_bits;
  logic         res_cout;
  logic [WIDTH-1:0] hi_sum;
  logic booth_ph, drain_ph, sum_ph, adv;

  assign booth_ph = cnt_q < DRAIN;
  assign drain_ph = cnt_q == DRAIN;
  assign sum_ph   = cnt_q == SUMUP;
  assign ready_o  = cnt_q == DONE;
  assign adv      = step_i && !ready_o;

  booth_dec u_dec (
    .pair_i (a_q[1:0]),
    .prev_i (prev_q),
    .dig_o  (dig)
  );

  mul_sel #(.WIDTH(WIDTH)) u_sel (
    .b_i    (b_q),
    .dig_i  (dig),
    .mult_o (mult)
  );

  // the drain step reuses the adder row to fold in the sign correction
  assign addend = booth_ph ? mult : {2'b00, CORR};

  csa_row #(.W(W)) u_csa (
    .x_i   (s_q),
    .y_i   (c_q),
    .z_i   (addend),
    .sum_o (csa_s),
    .cry_o (csa_c)
  );

  resolve_unit u_res (
    .sum_i  (pend_s_q),
    .cry_i  (pend_c_q),
    .neg_i  (pend_n_q),
    .cin_i  (rc_q),
    .bits_o (res_bits),
    .cout_o (res_cout)
  );

  ripple_add #(.WIDTH(WIDTH)) u_rip (
    .x_i   (s_q[WIDTH-1:0]),
    .y_i   (c_q[WIDTH-1:0]),
    .cin_i (rc_q),
    .sum_o (hi_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      hi_q     <= '0;
      prev_q   <= 1'b0;
      rc_q     <= 1'b0;
      s_q      <= '0;
      c_q      <= '0;
      pend_s_q <= '0;
      pend_c_q <= 1'b0;
      pend_n_q <= 1'b0;
      cnt_q    <= DONE;
    end else if (load_i) begin
      a_q      <= a_i;
      b_q      <= b_i;
      hi_q     <= '0;
      prev_q   <= 1'b0;
      rc_q     <= 1'b0;
      s_q      <= '0;
      c_q      <= '0;
      pend_s_q <= '0;
      pend_c_q <= 1'b0;
      pend_n_q <= 1'b0;
      cnt_q    <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + CW'(1);
      if (booth_ph || drain_ph) begin
        a_q  <= {res_bits, a_q[WIDTH-1:2]};
        rc_q <= res_cout;
      end
      if (booth_ph) begin
        prev_q   <= a_q[1];
        s_q      <= {2'b00, csa_s[W-1:2]};
        c_q      <= {1'b0, csa_c[W-1:1]};
        pend_s_q <= csa_s[1:0];
        pend_c_q <= csa_c[0];
        pend_n_q <= dig.neg;
      end
      if (drain_ph) begin
        s_q      <= csa_s;
        c_q      <= {csa_c[W-2:0], 1'b0};
        pend_s_q <= '0;
        pend_c_q <= 1'b0;
        pend_n_q <= 1'b0;
      end
      if (sum_ph) hi_q <= hi_sum;
    end
  end

  assign product_o = {hi_q, a_q};

  a_r2_load_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ready_o);

  a_r3_ready_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(step_i) && !$past(load_i));

  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DONE);

  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !load_i |=> ready_o && $stable(product_o));

  a_r6_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !step_i |=> $stable(product_o) && $stable(ready_o));

  a_r4_no_neg_zero_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    booth_ph && dig.zero |-> !dig.neg && !dig.two);

endmodule

// File: tb/test_iter_booth_mul.sv
module test_iter_booth_mul;
  localparam int N     = 16;
  localparam int STEPS = N / 2 + 2;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           load_i = 1'b0;
  logic [N-1:0]   a_i = '0;
  logic [N-1:0]   b_i = '0;
  logic           step_i = 1'b0;
  logic [2*N-1:0] product_o;
  logic           ready_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  iter_booth_mul #(.WIDTH(N)) i_iter_booth_mul (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .step_i    (step_i),
    .product_o (product_o),
    .ready_o   (ready_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] ax, bx;
    ax = {{N{a[N-1]}}, a};
    bx = {{N{b[N-1]}}, b};
    return ax * bx;
  endfunction

  // load, then STEPS step pulses with optional idle gaps (R2, R3, R4, R6, R8)
  task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b,
                         input int gap, input bit step_on_load, input string req);
    @(negedge clk_i);
    load_i = 1'b1; a_i = a; b_i = b; step_i = step_on_load;
    @(negedge clk_i);
    load_i = 1'b0; step_i = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (gap > 0) repeat (gap) @(negedge clk_i);
      if (i == 0) check(ready_o == 1'b0, "R2 ready low after load", {31'b0, ready_o}, '0);
      if (i == STEPS - 1)
        check(ready_o == 1'b0, step_on_load ? "R8 step on load not counted" : "R3 ready not early",
              {31'b0, ready_o}, '0);
      step_i = 1'b1;
      @(negedge clk_i);
      step_i = 1'b0;
    end
    check(ready_o == 1'b1, "R3 ready after last step", {31'b0, ready_o}, 1);
    check(product_o == ref_mul(a, b), req, product_o, ref_mul(a, b));
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(ready_o == 1'b1, "R1 ready at reset", {31'b0, ready_o}, 1);
    check(product_o == '0, "R1 product zero at reset", product_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_basic;
    run_mul(16'd3, 16'd5, 0, 1'b0, "R4 small positive");
    run_mul(16'hFFF9, 16'd11, 0, 1'b0, "R4 negative times positive");
    run_mul(16'd1234, 16'hFC18, 0, 1'b0, "R4 positive times negative");
  endtask

  task automatic t_random;
    for (int i = 0; i < 40; i++)
      run_mul(N'($urandom), N'($urandom), 0, 1'b0, "R4 random operands");
  endtask

  task automatic t_corners;
    run_mul(16'h8000, 16'h8000, 0, 1'b0, "R5 most-negative squared");
    run_mul(16'h8000, 16'h7FFF, 0, 1'b0, "R5 most-negative times max");
    run_mul(16'h7FFF, 16'h7FFF, 0, 1'b0, "R5 max squared");
    run_mul(16'h0000, 16'h9ABC, 0, 1'b0, "R5 zero times operand");
    run_mul(16'h5A5A, 16'h0000, 0, 1'b0, "R5 operand times zero");
    run_mul(16'hFFFF, 16'hFFFF, 0, 1'b0, "R5 minus one squared");
    run_mul(16'hFFFF, 16'h8000, 0, 1'b0, "R5 minus one times most-negative");
    run_mul(16'h1357, 16'hFFFF, 0, 1'b0, "R5 operand times minus one");
  endtask

  task automatic t_gaps;
    run_mul(16'hB00F, 16'h3C21, 3, 1'b0, "R6 result with idle gaps");
    run_mul(16'h7001, 16'h8765, 1, 1'b0, "R6 result with single gaps");
  endtask

  task automatic t_after_done;
    logic [2*N-1:0] held;
    run_mul(16'h4321, 16'hEDCB, 0, 1'b0, "R4 before extra steps");
    held = product_o;
    @(negedge clk_i);
    step_i = 1'b1;
    repeat (5) @(negedge clk_i);
    step_i = 1'b0;
    check(product_o == held, "R7 product held after extra steps", product_o, held);
    check(ready_o == 1'b1, "R7 ready held after extra steps", {31'b0, ready_o}, 1);
  endtask

  task automatic t_load_step;
    run_mul(16'hA5A5, 16'h0F0F, 0, 1'b1, "R8 product with step on load");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_random();
    t_corners();
    t_gaps();
    t_after_done();
    t_load_step();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule